// File: doc/BRIEF.md
# Single-Cycle Register/Memory Core

This block is a compact 32-bit processor core in which every instruction completes in one clock. On each cycle it places the program counter on an instruction fetch port and takes the returned word in the same cycle. It decodes that word and reads two operands from a 32-entry register file. It then either performs a wrapping add or subtract, or forms a memory address and accesses a data port. The result is written back on the closing clock edge. The instruction and data ports are combinational request/response ports, so the surrounding memories must answer within the cycle.

The core recognises six instructions. Two are register-to-register: add and subtract. Four move data between the registers and memory: whole words and single bytes, in both directions. All four memory operations share one adder, which adds the base register and a sign-extended 16-bit offset. Memory is treated as big-endian: the byte at the lowest address of a word sits in that word's most significant lane. Any other encoding leaves all state untouched except the program counter.

Top module: `lsc_core`

## Requirements
- R1: While the synchronised reset is active (`rst_n` low, and for two rising edges after it is released), `imem_addr` is 0 and `dmem_we` is 0.
- R2: Once out of reset, `imem_addr` advances by exactly 4 on every clock edge.
- R3: Bits [31:26]=0 with bits [5:0]=32 writes register[15:11] = register[25:21] + register[20:16], modulo 2^32.
- R4: Bits [31:26]=0 with bits [5:0]=34 writes register[15:11] = register[25:21] − register[20:16], modulo 2^32.
- R5: Opcode 35 loads the data-port word into register[20:16]. The address is register[25:21] plus the sign-extended offset in bits [15:0].
- R6: Opcode 43 drives the register[20:16] value on `dmem_wdata` with `dmem_we`=1 and all four byte enables set, at the same address form.
- R7: Opcode 32 loads one byte, sign-extended to 32 bits, into register[20:16]. Address offset 0 within a word selects bits [31:24] and offset 3 selects bits [7:0].
- R8: Opcode 40 writes the low byte of register[20:16] to exactly one lane, enable bit 3−(address mod 4). The other three bytes of the word are unchanged.
- R9: Register 0 always reads as 0. Writes addressed to it are discarded.
- R10: Any other opcode, or opcode 0 with any other function code, changes no register and raises no memory write.
- R11: A register written by one instruction is read with its new value by the very next instruction.
- R12: Negative offsets produce addresses below the base register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_data | input | 32 | Instruction word returned in the same cycle |
| dmem_addr | output | 32 | Byte address for the data access |
| dmem_we | output | 1 | Data write strobe |
| dmem_be | output | 4 | Byte lane enables; bit 3 is bits [31:24] |
| dmem_wdata | output | 32 | Store data; byte stores replicate the byte in every lane |
| dmem_rdata | input | 32 | Word read from the data port, returned in the same cycle |

## Verification
Add and subtract are swept over every ordered pair drawn from eight operand values: zero, one, both signed extremes, all ones, and mixed halves. This sweep separates correct wrapping from saturation or sign errors, and shows whether the operand order in subtract is right. Within the same program, a write to register 0, a bad function code and an unknown store-like opcode show whether illegal work is really suppressed. A dependent add/subtract chain shows that results are forwarded through the register file by the next cycle. A separate byte program reads each of the four lanes of a word holding 0x80, 0x7F, 0x01 and 0xFE, so both the lane order and the sign extension are exposed. It writes them back in reverse lane order through negative and positive offsets, and a merge into a prefilled word confirms that the neighbouring bytes survive.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int INSTR_W = 32;
  localparam int FIELD_W = 5;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OPC_ALU = 6'd0;
  localparam logic [5:0] OPC_LDW = 6'd35;
  localparam logic [5:0] OPC_STW = 6'd43;
  localparam logic [5:0] OPC_LDB = 6'd32;
  localparam logic [5:0] OPC_STB = 6'd40;
  localparam logic [5:0] FNC_ADD = 6'd32;
  localparam logic [5:0] FNC_SUB = 6'd34;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_LDW, K_STW, K_LDB, K_STB
  } op_kind_e;

  typedef struct packed {
    op_kind_e             kind;
    logic [FIELD_W-1:0]   ra;
    logic [FIELD_W-1:0]   rb;
    logic [FIELD_W-1:0]   rd;
    logic [IMM_W-1:0]     imm;
  } dec_t;
endpackage

// File: rtl/lsc_rst_sync.sv
module lsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/lsc_decode.sv
module lsc_decode
  import lsc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [5:0] opc;
  logic [5:0] fnc;

  assign opc = instr_i[31:26];
  assign fnc = instr_i[5:0];

  always_comb begin
    dec_o.ra   = instr_i[25:21];
    dec_o.rb   = instr_i[20:16];
    dec_o.rd   = instr_i[15:11];
    dec_o.imm  = instr_i[15:0];
    dec_o.kind = K_NOP;
    unique case (opc)
      OPC_ALU: begin
        if (fnc == FNC_ADD)      dec_o.kind = K_ADD;
        else if (fnc == FNC_SUB) dec_o.kind = K_SUB;
      end
      OPC_LDW: dec_o.kind = K_LDW;
      OPC_STW: dec_o.kind = K_STW;
      OPC_LDB: dec_o.kind = K_LDB;
      OPC_STB: dec_o.kind = K_STB;
      default: dec_o.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [XLEN-1:0] rd_data_a,
  output logic [XLEN-1:0] rd_data_b
);
  logic [XLEN-1:0] regs_q [NREG];
  logic            wr_ok;

  assign wr_ok = wr_en && (wr_addr != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) regs_q[wr_addr] <= wr_data;
  end

  assign rd_data_a = (rd_addr_a == '0) ? '0 : regs_q[rd_addr_a];
  assign rd_data_b = (rd_addr_b == '0) ? '0 : regs_q[rd_addr_b];
endmodule

// File: rtl/lsc_lsu.sv
module lsc_lsu
  import lsc_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB  = XLEN / 8,
  localparam int OW  = $clog2(NB)
) (
  input  logic             en,
  input  op_kind_e         kind,
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic             mem_we,
  output logic [NB-1:0]    mem_be,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [XLEN-1:0]  load_val
);
  logic [XLEN-1:0] offs;
  logic [OW-1:0]   lane;
  logic [7:0]      pick;

  assign offs     = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign mem_addr = base + offs;
  assign lane     = OW'(NB-1) - mem_addr[OW-1:0];
  assign pick     = mem_rdata[8*lane +: 8];

  always_comb begin
    mem_be    = '0;
    mem_wdata = src;
    load_val  = mem_rdata;
    unique case (kind)
      K_STW: mem_be = '1;
      K_STB: begin
        mem_be    = NB'(1) << lane;
        mem_wdata = {NB{src[7:0]}};
      end
      K_LDB: load_val = {{(XLEN-8){pick[7]}}, pick};
      default: ;
    endcase
  end

  assign mem_we = en && ((kind == K_STW) || (kind == K_STB));
endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREG    = 32,
  parameter int PC_STEP = 4,
  localparam int NB     = XLEN / 8,
  localparam int RAW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic            dmem_we,
  output logic [NB-1:0]   dmem_be,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic            rst_q;
  logic [XLEN-1:0] pc_q, pc_d;
  dec_t            dec;
  logic [XLEN-1:0] rs_val, rt_val, alu_val, load_val, wb_val;
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [RAW-1:0]  rs_a;

  lsc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  always_comb pc_d = pc_q + XLEN'(PC_STEP);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  lsc_decode u_dec (.instr_i(imem_data), .dec_o(dec));

  assign rs_a = RAW'(dec.ra);

  lsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .wr_en(rf_we), .wr_addr(rf_waddr), .wr_data(wb_val),
    .rd_addr_a(rs_a), .rd_addr_b(RAW'(dec.rb)),
    .rd_data_a(rs_val), .rd_data_b(rt_val)
  );

  always_comb begin
    alu_val = (dec.kind == K_SUB) ? (rs_val - rt_val) : (rs_val + rt_val);
  end

  lsc_lsu #(.XLEN(XLEN)) u_lsu (
    .en(rst_q), .kind(dec.kind), .base(rs_val), .imm(dec.imm), .src(rt_val),
    .mem_rdata(dmem_rdata), .mem_addr(dmem_addr), .mem_we(dmem_we),
    .mem_be(dmem_be), .mem_wdata(dmem_wdata), .load_val(load_val)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = RAW'(dec.rb);
    wb_val   = load_val;
    unique case (dec.kind)
      K_ADD, K_SUB: begin
        rf_we    = rst_q;
        rf_waddr = RAW'(dec.rd);
        wb_val   = alu_val;
      end
      K_LDW, K_LDB: rf_we = rst_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/lsc_core_chk.sv
module lsc_core_chk #(
  parameter int XLEN    = 32,
  parameter int RAW     = 5,
  parameter int NB      = 4,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst_q,
  input logic [XLEN-1:0] pc,
  input logic [5:0]      opc,
  input logic            dmem_we,
  input logic [NB-1:0]   dmem_be,
  input logic [RAW-1:0]  rs_addr,
  input logic [XLEN-1:0] rs_data,
  input logic            rf_we
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst_q)
    !rst_q |-> (!dmem_we && pc == '0));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_q)
    rst_q |=> (pc == $past(pc) + XLEN'(PC_STEP)));

  p_word_store_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (opc == 6'd43) |-> (dmem_we && dmem_be == '1));

  p_byte_store_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (opc == 6'd40) |-> (dmem_we && $countones(dmem_be) == 1));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (rs_addr == '0) |-> (rs_data == '0));

  p_store_only_r10: assert property (@(posedge clk) disable iff (!rst_q)
    dmem_we |-> (opc == 6'd43 || opc == 6'd40));

  p_rf_legal_r10: assert property (@(posedge clk) disable iff (!rst_q)
    rf_we |-> (opc == 6'd0 || opc == 6'd35 || opc == 6'd32));
endmodule

bind lsc_core lsc_core_chk #(.XLEN(XLEN), .RAW(RAW), .NB(NB), .PC_STEP(PC_STEP)) chk_i (
  .clk(clk), .rst_q(rst_q), .pc(pc_q), .opc(imem_data[31:26]),
  .dmem_we(dmem_we), .dmem_be(dmem_be), .rs_addr(rs_a), .rs_data(rs_val),
  .rf_we(rf_we)
);

// File: tb/lsc_core_tb.sv
module lsc_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [3:0]  dmem_be;

  logic [31:0] prog [64];
  logic [31:0] dmem [64];
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsc_core dut_i (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_be(dmem_be),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = (imem_addr[31:8] == '0) ? prog[imem_addr[7:2]] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) begin
      for (int b = 0; b < 4; b++)
        if (dmem_be[b]) dmem[dmem_addr[7:2]][8*b +: 8] <= dmem_wdata[8*b +: 8];
    end
  end

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] i_ins(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) begin
      prog[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic run(int cycles, bit pc_check);
    logic [31:0] prev;
    int steps;
    rst_n = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check("R1 reset pc", imem_addr, 32'h0);
      check("R1 reset no write", {31'd0, dmem_we}, 32'h0);
    end
    rst_n = 1'b1;
    prev = imem_addr;
    steps = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (pc_check && c < 12 && imem_addr != prev) begin
        check("R2 pc step", imem_addr, prev + 32'd4);
        steps++;
      end
      prev = imem_addr;
    end
    if (pc_check) check("R2 pc moved", {31'd0, steps > 0}, 32'd1);
  endtask

  task automatic arith_case(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    rst_n = 1'b0;
    clear_all();
    dmem[0] = a;
    dmem[1] = b;
    dmem[7] = 32'hDEADBEEF;
    prog[0]  = i_ins(35, 0, 1, 0);
    prog[1]  = i_ins(35, 0, 2, 4);
    prog[2]  = r_ins(1, 2, 3, 32);
    prog[3]  = r_ins(1, 2, 4, 34);
    prog[4]  = r_ins(2, 1, 5, 34);
    prog[5]  = r_ins(1, 2, 0, 32);
    prog[6]  = r_ins(4, 4, 3, 33);
    prog[7]  = i_ins(4, 1, 4, 16);
    prog[8]  = i_ins(43, 0, 3, 8);
    prog[9]  = i_ins(43, 0, 4, 12);
    prog[10] = i_ins(43, 0, 5, 16);
    prog[11] = i_ins(43, 0, 0, 20);
    prog[12] = r_ins(3, 0, 6, 32);
    prog[13] = r_ins(6, 2, 6, 34);
    prog[14] = i_ins(43, 0, 6, 24);
    prog[15] = i_ins(41, 0, 1, 28);
    run(24, 1'b0);
    check("R3/R10 add wraps, bad funct ignored", dmem[2], a + b);
    check("R4 sub a-b", dmem[3], a - b);
    check("R4 sub b-a", dmem[4], b - a);
    check("R9 reg0 stays zero", dmem[5], 32'h0);
    check("R11 back-to-back chain", dmem[6], a);
    check("R10 unknown opcode no store", dmem[7], 32'hDEADBEEF);
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
    vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    vals[6] = 32'hFFFF_0000; vals[7] = 32'h0001_0001;

    // byte and word transfer program, also checks pc stepping
    clear_all();
    dmem[0]  = 32'd64;
    dmem[2]  = 32'hCAFEF00D;
    dmem[8]  = 32'h807F01FE;
    dmem[13] = 32'h11223344;
    prog[0] = i_ins(35, 0, 6, 0);
    for (int k = 0; k < 4; k++) begin
      prog[1+k]  = i_ins(32, 6, 7+k, -32+k);
      prog[5+k]  = i_ins(43, 6, 7+k, 16+4*k);
      prog[9+k]  = i_ins(40, 6, 7+k, 32+3-k);
    end
    prog[13] = i_ins(40, 6, 7, -11);
    prog[14] = i_ins(35, 6, 11, -56);
    prog[15] = i_ins(43, 6, 11, -4);
    run(24, 1'b1);
    check("R7/R12 byte lane0 sign-extended", dmem[20], 32'hFFFFFF80);
    check("R7 byte lane1", dmem[21], 32'h0000007F);
    check("R7 byte lane2", dmem[22], 32'h00000001);
    check("R7 byte lane3 sign-extended", dmem[23], 32'hFFFFFFFE);
    check("R8 byte stores reversed", dmem[24], 32'hFE017F80);
    check("R8 byte merge keeps neighbours", dmem[13], 32'h11803344);
    check("R5/R6/R12 word copy negative offset", dmem[15], 32'hCAFEF00D);
    check("R8 source word untouched", dmem[8], 32'h807F01FE);

    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        arith_case(vals[i], vals[j]);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule